// File: doc/BRIEF.md
# Firmware Image Scrambler

This block converts a plain firmware image into a scrambled upgrade stream. Software or a host engine pulses `start` with the image size in bytes, then streams the image bytes in increasing address order over a valid/ready input. Each byte is encoded as it arrives: it is inverted and then rotated left by one bit. The encoded byte is written into an internal buffer, and a running 16-bit checksum is updated at the same time.

Once the whole image has been taken in, the block sends a six-byte header on a valid/ready output. The header holds the byte count and then the checksum. After the header comes the payload, reordered as four interleaved segments. A byte at address `a` belongs to segment `a mod 4` and sits at offset `a / 4` within that segment. Segments are sent in order 0, 1, 2, 3, and each is sent in increasing offset order.

A size of zero, a size that is not a multiple of four, or a size larger than the buffer is refused. The block raises an error flag and produces no output.

Top module: `fw_scrambler`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `out_last` and `size_err` are all low.
- R2: After a `start` with a legal size, `in_ready` is high until exactly `img_size` bytes have been accepted, and then it drops. `in_ready` and `out_valid` are never high together.
- R3: Each payload byte equals the input byte inverted and then rotated left by one bit, so that bit 7 of the inverted byte moves to bit 0. For example, 0x80 becomes 0xFE and 0x01 becomes 0xFD.
- R4: The first four output bytes carry the 32-bit `img_size`, most significant byte first.
- R5: Output bytes 5 and 6 carry the 16-bit wraparound sum of all encoded payload bytes, high byte first.
- R6: The payload byte at output position `(a mod 4)*(img_size/4) + a/4` comes from input address `a`. That is, segment 0 is sent in full, then segments 1, 2 and 3, each in increasing offset order.
- R7: `out_last` is high only with the final payload byte. After that byte is taken, `out_valid` drops.
- R8: A `start` with a size that is zero, not a multiple of four, or larger than `MAX_BYTES` sets `size_err` on the next cycle, and the block produces no input readiness and no output. `size_err` clears at the next `start`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new image; sampled only when idle |
| img_size | input | 32 | Image size in bytes, taken with `start` |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input image byte |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Header or payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Sink accepts an output byte |
| size_err | output | 1 | Last `start` carried an illegal size |

## Verification
A four-byte image holding 0x80, 0x01, 0x00 and 0xFF isolates the bit encoding: with one byte per segment, the order cannot mask a rotate in the wrong direction or a missing inversion. Larger ramp and strided images, including one that fills the buffer, have a distinct value at every address. These separate a correct segment interleave from a plain pass-through or a transposed offset, and they give checksums that reveal a dropped or doubled byte. An all-0xFF image encodes to all zeros, which exposes a checksum that sums raw bytes instead of encoded ones. Images run with input gaps and with output backpressure exercise the hold rule. Sizes of 6, 0 and 68 confirm that every illegal size is refused.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SIZE_BITS = 32;
    localparam int HDR_BYTES = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HDR,
        ST_PAY
    } scr_state_e;

    // invert, then rotate left by one
    function automatic logic [7:0] scr_encode(input logic [7:0] raw);
        logic [7:0] inv;
        inv = ~raw;
        return {inv[6:0], inv[7]};
    endfunction

endpackage

// File: rtl/scr_xform.sv
module scr_xform (
    input  logic [7:0] raw,
    output logic [7:0] coded
);
    import scr_pkg::*;

    always_comb coded = scr_encode(raw);

endmodule

// File: rtl/scr_store.sv
module scr_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/scr_order.sv
module scr_order #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-2:0] quarter,
    output logic [AW-1:0] rd_addr,
    output logic          at_end
);
    localparam int OW = AW - 2;

    logic [1:0]    seg;
    logic [OW-1:0] off;
    logic [AW-2:0] lim;
    logic          seg_done;

    assign lim      = quarter - 1'b1;
    assign seg_done = ({1'b0, off} == lim);
    assign rd_addr  = {off, seg};
    assign at_end   = seg_done && (seg == 2'd3);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seg <= '0;
            off <= '0;
        end else if (step) begin
            if (seg_done) begin
                off <= '0;
                seg <= seg + 2'd1;
            end else begin
                off <= off + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fw_scrambler.sv
module fw_scrambler #(
    parameter int MAX_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] img_size,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready,
    output logic        size_err
);
    import scr_pkg::*;

    localparam int AW = $clog2(MAX_BYTES);

    scr_state_e  state;
    logic [31:0] size_q;
    logic [AW:0] wr_cnt;
    logic [2:0]  hdr_idx;
    logic [15:0] csum;
    logic        err_q;

    logic [7:0]    coded;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic          at_end;
    logic          accept, fire, size_ok, go;

    assign size_ok = (img_size != '0) && (img_size[1:0] == 2'b00)
                   && (img_size <= MAX_BYTES);
    assign go      = (state == ST_IDLE) && start;
    assign accept  = in_valid && in_ready;
    assign fire    = out_valid && out_ready;

    assign in_ready  = (state == ST_LOAD);
    assign out_valid = (state == ST_HDR) || (state == ST_PAY);
    assign out_last  = (state == ST_PAY) && at_end;
    assign size_err  = err_q;

    scr_xform i_xform (.raw(in_data), .coded(coded));

    scr_store #(.DEPTH(MAX_BYTES), .AW(AW)) i_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (wr_cnt[AW-1:0]),
        .wr_data (coded),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    scr_order #(.AW(AW)) i_order (
        .clk     (clk),
        .rst     (rst),
        .clear   (go),
        .step    (fire && (state == ST_PAY)),
        .quarter (size_q[AW:2]),
        .rd_addr (rd_addr),
        .at_end  (at_end)
    );

    always_comb begin
        out_data = rd_data;
        if (state == ST_HDR) begin
            case (hdr_idx)
                3'd0:    out_data = size_q[31:24];
                3'd1:    out_data = size_q[23:16];
                3'd2:    out_data = size_q[15:8];
                3'd3:    out_data = size_q[7:0];
                3'd4:    out_data = csum[15:8];
                default: out_data = csum[7:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            size_q  <= '0;
            wr_cnt  <= '0;
            hdr_idx <= '0;
            csum    <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err_q   <= !size_ok;
                        size_q  <= img_size;
                        wr_cnt  <= '0;
                        hdr_idx <= '0;
                        csum    <= '0;
                        if (size_ok) state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        csum   <= csum + {8'd0, coded};
                        wr_cnt <= wr_cnt + 1'b1;
                        if (wr_cnt == size_q[AW:0] - 1'b1) state <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        hdr_idx <= hdr_idx + 3'd1;
                        if (hdr_idx == 3'(HDR_BYTES - 1)) state <= ST_PAY;
                    end
                end
                default: begin
                    if (fire && at_end) state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fw_scrambler_chk.sv
module fw_scrambler_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_ready,
    input logic       size_err
);
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R2

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        size_err |-> (!out_valid && !in_ready)); // R8

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R7

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

bind fw_scrambler fw_scrambler_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .size_err  (size_err)
);

// File: tb/test_fw_scrambler.sv
module test_fw_scrambler;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] img_size = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        size_err;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    int bp_mode = 0;
    int cyc     = 0;

    logic [7:0] img [MAXB];
    logic [7:0] q_data [$];
    logic       q_last [$];
    int         q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fw_scrambler #(.MAX_BYTES(MAXB)) i_fw_scrambler (
        .clk(clk), .rst(rst), .start(start), .img_size(img_size),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .size_err(size_err)
    );

    function automatic logic [7:0] enc(input logic [7:0] b);
        logic [7:0] n;
        n = b ^ 8'hFF;
        return (n << 1) | (n >> 7);
    endfunction

    function automatic string tagname(input int t);
        case (t)
            4: return "R4";
            5: return "R5";
            default: return "R6/R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    initial begin
        logic       prev_stall;
        logic [7:0] prev_data;
        prev_stall = 1'b0;
        prev_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (!rst && prev_stall)
                check(out_valid && (out_data == prev_data), "R9", int'(out_data), int'(prev_data));
            if (!rst && out_valid && out_ready) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R7", int'(out_data), -1);
                end else begin
                    logic [7:0] ed;
                    logic       el;
                    int         et;
                    ed = q_data.pop_front();
                    el = q_last.pop_front();
                    et = q_tag.pop_front();
                    check(out_data == ed, tagname(et), int'(out_data), int'(ed));
                    check(out_last == el, "R7", int'(out_last), int'(el));
                end
            end
            prev_stall = !rst && out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic push(input logic [7:0] d, input logic l, input int t);
        q_data.push_back(d);
        q_last.push_back(l);
        q_tag.push_back(t);
    endtask

    task automatic run_image(input int size, input bit gaps);
        logic [15:0] sum;
        int          qtr;
        sum = '0;
        for (int i = 0; i < size; i++) sum = sum + 16'(enc(img[i]));
        qtr = size / 4;
        push(8'(size >> 24), 1'b0, 4);
        push(8'(size >> 16), 1'b0, 4);
        push(8'(size >> 8),  1'b0, 4);
        push(8'(size),       1'b0, 4);
        push(sum[15:8], 1'b0, 5);
        push(sum[7:0],  1'b0, 5);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < qtr; o++)
                push(enc(img[o*4 + s]), (s == 3) && (o == qtr - 1), 6);

        @(negedge clk);
        start = 1'b1;
        img_size = size;
        @(negedge clk);
        start = 1'b0;
        check(size_err == 1'b0, "R8", int'(size_err), 0);
        for (int i = 0; i < size; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = img[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2", int'(in_ready), 0);
        while (q_data.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    endtask

    task automatic bad_size(input int size);
        @(negedge clk);
        start = 1'b1;
        img_size = size;
        @(negedge clk);
        start = 1'b0;
        #2;
        check(size_err == 1'b1, "R8", int'(size_err), 1);
        check(in_ready == 1'b0, "R8", int'(in_ready), 0);
        repeat (4) begin
            @(negedge clk);
            #2;
            check(out_valid == 1'b0, "R8", int'(out_valid), 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(in_ready == 1'b0,  "R1", int'(in_ready), 0);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_last == 1'b0,  "R1", int'(out_last), 0);
        check(size_err == 1'b0,  "R1", int'(size_err), 0);

        // R3: encoding corners, one byte per segment
        img[0] = 8'h80; img[1] = 8'h01; img[2] = 8'h00; img[3] = 8'hFF;
        run_image(4, 1'b0);

        // R6: ramp, distinct per address
        for (int i = 0; i < 16; i++) img[i] = 8'(i);
        run_image(16, 1'b0);

        // R8: illegal sizes, then recovery
        bad_size(6);
        bad_size(0);
        bad_size(MAXB + 4);

        // R5: all ones encode to zero
        for (int i = 0; i < 8; i++) img[i] = 8'hFF;
        run_image(8, 1'b0);

        // R9: full buffer, strided data, gaps and backpressure
        bp_mode = 1;
        for (int i = 0; i < MAXB; i++) img[i] = 8'(i * 37 + 5);
        run_image(MAXB, 1'b1);
        for (int i = 0; i < 12; i++) img[i] = 8'(200 - i * 11);
        run_image(12, 1'b1);
        bp_mode = 0;

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule